// File: doc/BRIEF.md
# Clock Synthesizer Control and Post-Divider

This block keeps the control fields of a clock synthesizer and builds the system clock from a fast PLL output. Software writes one control word. The word holds a 3-bit multiply code, a 3-bit reduced-divide code, a loss-of-clock enable, a loss-of-clock reset enable and a clock-output disable. The block reports the effective multiplication factor. It drops its lock indication and asks for a relock when the multiply code changes. It turns a loss-of-clock status into an immediate reset request only when both enables allow it. It also drives a gated copy of the system clock on the clock output.

The analog PLL, the lock detector and the missing-clock detector sit outside the block and arrive as plain inputs. The input clock `clk` runs at twice the PLL output rate. The system clock is a registered toggle. Its high phase and its low phase each last 2^R `clk` cycles, so it runs at the PLL output frequency divided by 2^R, and divide-by-1 needs no gated clock. A new divide code waits for the next falling edge of the current system clock. While lock is missing, a new divide code is held until lock returns. This keeps the output from overshooting during relock and means no runt pulse is ever emitted.

Top module: `sysclk_ctrl`

## Requirements
- R1: The control word has these fields: multiply code M at wr_data[2:0], divide code R at wr_data[5:3], loss-of-clock enable at wr_data[6], loss-of-clock reset enable at wr_data[7] and clock-output disable at wr_data[8]. A write is taken at the rising edge where wr_en is 1. In normal mode (mode 0, or 3) mult_factor equals 2*(M+2) from the cycle after the write edge. The reset value of M is 1, so mult_factor is 6 after reset.
- R2: With div_active = R, the high phase and the low phase of sys_clk each last 2^R clk cycles. The reset value of R is 0, and sys_clk is 0 in reset.
- R3: div_active changes only at the clk edge where sys_clk goes from 1 to 0. A write of R alone raises no relock_req and leaves lock_ok high.
- R4: In normal mode, a write whose M differs from the stored M makes relock_req 1 for one cycle and lock_ok 0 from the next cycle. lock_ok stays 0 until pll_lock has been sampled 0. After that, lock_ok follows pll_lock one cycle late. A write with the same M changes neither output.
- R5: In one-to-one mode (mode 1) and in external mode (mode 2), mult_factor is 1 and an M write raises no relock.
- R6: lc_reset is 1 in the cycle after lc_flag is sampled 1 only when the loss-of-clock enable and the reset enable are both 1 and the mode is not external. Otherwise it is 0.
- R7: With the clock-output disable at 1, clkout is 0. With it at 0, clkout equals sys_clk in every cycle.
- R8: When stop_pll_off is sampled 1, relock_req is 1 and lock_ok is 0 in the next cycle, whatever the loss-of-clock enable holds.
- R9: A divide code written while lock_ok is 0 (outside external mode) is held. It reaches div_active at the first sys_clk falling edge after lock_ok is 1 again.
- R10: mul_invalid is 1 one cycle after M = 0 and ref_slow = 1 are seen together in normal mode. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock at twice the PLL output rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 9 | Control word |
| pll_lock | input | 1 | Lock status from the lock detector |
| stop_pll_off | input | 1 | PLL disabled in stop mode |
| lc_flag | input | 1 | Loss-of-clock status |
| ref_slow | input | 1 | Reference clock below the minimum for M = 0 |
| mode | input | 2 | 0 normal, 1 one-to-one, 2 external clock |
| sys_clk | output | 1 | Divided system clock |
| clkout | output | 1 | Gated copy of sys_clk |
| div_active | output | 3 | Divide code now in force |
| lock_ok | output | 1 | Lock-valid indication |
| relock_req | output | 1 | Relock request pulse |
| lc_reset | output | 1 | Loss-of-clock reset request |
| mult_factor | output | 5 | Effective multiplication factor |
| mul_invalid | output | 1 | M = 0 used with a slow reference |

## Verification
Every status output is registered from next-state values. So mult_factor, relock_req, lock_ok, lc_reset and mul_invalid are due one clk cycle after the edge that samples the write or the input, and clkout follows sys_clk in the same cycle. The bench drives inputs on falling clk edges and reads results on the following falling edge, one rising edge later. A divide change takes up to one full old period plus one edge to appear. The bench therefore polls div_active with a bound and only then measures both phases of sys_clk edge by edge.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  typedef enum logic [1:0] {
    MODE_PLL = 2'd0,
    MODE_ONE = 2'd1,
    MODE_EXT = 2'd2,
    MODE_ALT = 2'd3
  } clk_mode_e;
endpackage

// File: rtl/sc_ctrl_regs.sv
module sc_ctrl_regs
  import sysclk_pkg::*;
#(
  parameter int MUL_W   = 3,
  parameter int DIV_W   = 3,
  parameter int RST_MUL = 1,
  parameter int RST_DIV = 0,
  localparam int WR_W   = MUL_W + DIV_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             pll_lock,
  input  logic             stop_pll_off,
  input  clk_mode_e        mode_e,
  output logic [MUL_W-1:0] mul_q,
  output logic [DIV_W-1:0] div_q,
  output logic             clkout_off_q,
  output logic             lc_en_q,
  output logic [MUL_W-1:0] mul_nx,
  output logic             lc_en_nx,
  output logic             lc_rst_nx,
  output logic             off_nx,
  output logic             lock_ok,
  output logic             relock_req
);
  localparam int DIV_LO = MUL_W;
  localparam int DIV_HI = MUL_W + DIV_W - 1;
  localparam int LCE_B  = MUL_W + DIV_W;
  localparam int LCR_B  = LCE_B + 1;
  localparam int OFF_B  = LCE_B + 2;

  logic             lc_rst_q;
  logic             lost_q;
  logic [DIV_W-1:0] div_nx;
  logic             pll_mode;
  logic             mul_chg;
  logic             lost_set;
  logic             lost_nx;

  always_comb begin
    mul_nx    = wr_en ? wr_data[MUL_W-1:0]    : mul_q;
    div_nx    = wr_en ? wr_data[DIV_HI:DIV_LO] : div_q;
    lc_en_nx  = wr_en ? wr_data[LCE_B]         : lc_en_q;
    lc_rst_nx = wr_en ? wr_data[LCR_B]         : lc_rst_q;
    off_nx    = wr_en ? wr_data[OFF_B]         : clkout_off_q;
    pll_mode  = (mode_e != MODE_ONE) && (mode_e != MODE_EXT);
    mul_chg   = wr_en && (wr_data[MUL_W-1:0] != mul_q) && pll_mode;
    lost_set  = mul_chg || stop_pll_off;
    lost_nx   = lost_set || (lost_q && pll_lock);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_q        <= MUL_W'(RST_MUL);
      div_q        <= DIV_W'(RST_DIV);
      lc_en_q      <= 1'b0;
      lc_rst_q     <= 1'b0;
      clkout_off_q <= 1'b0;
      lost_q       <= 1'b0;
      lock_ok      <= 1'b0;
      relock_req   <= 1'b0;
    end else begin
      mul_q        <= mul_nx;
      div_q        <= div_nx;
      lc_en_q      <= lc_en_nx;
      lc_rst_q     <= lc_rst_nx;
      clkout_off_q <= off_nx;
      lost_q       <= lost_nx;
      lock_ok      <= pll_lock && !lost_nx;
      relock_req   <= lost_set;
    end
  end
endmodule

// File: rtl/sc_post_div.sv
module sc_post_div #(
  parameter int DIV_W   = 3,
  parameter int RST_DIV = 0,
  localparam int HC_W   = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_req,
  input  logic             apply_ok,
  input  logic             off_nx,
  output logic             sys_clk,
  output logic             clkout,
  output logic [DIV_W-1:0] div_active
);
  logic [HC_W-1:0] hc;
  logic [HC_W:0]   span;
  logic [HC_W:0]   span_m1;
  logic [HC_W-1:0] last;
  logic            at_end;
  logic            fall;
  logic            sys_nx;

  always_comb begin
    span    = {{HC_W{1'b0}}, 1'b1} << div_active;
    span_m1 = span - 1'b1;
    last    = span_m1[HC_W-1:0];
    at_end  = (hc == last);
    fall    = at_end && sys_clk;
    sys_nx  = at_end ? !sys_clk : sys_clk;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc         <= '0;
      sys_clk    <= 1'b0;
      clkout     <= 1'b0;
      div_active <= DIV_W'(RST_DIV);
    end else begin
      hc      <= at_end ? '0 : hc + 1'b1;
      sys_clk <= sys_nx;
      clkout  <= sys_nx && !off_nx;
      if (fall && apply_ok) div_active <= div_req;
    end
  end
endmodule

// File: rtl/sc_status.sv
module sc_status
  import sysclk_pkg::*;
#(
  parameter int MUL_W = 3,
  localparam int MF_MAX = 2 * ((1 << MUL_W) + 1),
  localparam int MF_W   = $clog2(MF_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MUL_W-1:0] mul_nx,
  input  logic             lc_en_nx,
  input  logic             lc_rst_nx,
  input  logic             lc_flag,
  input  logic             ref_slow,
  input  clk_mode_e        mode_e,
  output logic             lc_reset,
  output logic [MF_W-1:0]  mult_factor,
  output logic             mul_invalid
);
  logic            pll_mode;
  logic [MF_W-1:0] mf_nx;

  always_comb begin
    pll_mode = (mode_e != MODE_ONE) && (mode_e != MODE_EXT);
    if (pll_mode) mf_nx = MF_W'({mul_nx, 1'b0}) + MF_W'(4);
    else          mf_nx = MF_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lc_reset    <= 1'b0;
      mult_factor <= '0;
      mul_invalid <= 1'b0;
    end else begin
      lc_reset    <= lc_en_nx && lc_rst_nx && lc_flag && (mode_e != MODE_EXT);
      mult_factor <= mf_nx;
      mul_invalid <= (mul_nx == '0) && ref_slow && pll_mode;
    end
  end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int MUL_W   = 3,
  parameter int DIV_W   = 3,
  parameter int RST_MUL = 1,
  parameter int RST_DIV = 0,
  localparam int WR_W   = MUL_W + DIV_W + 3,
  localparam int MF_W   = $clog2(2 * ((1 << MUL_W) + 1) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WR_W-1:0]  wr_data,
  input  logic             pll_lock,
  input  logic             stop_pll_off,
  input  logic             lc_flag,
  input  logic             ref_slow,
  input  logic [1:0]       mode,
  output logic             sys_clk,
  output logic             clkout,
  output logic [DIV_W-1:0] div_active,
  output logic             lock_ok,
  output logic             relock_req,
  output logic             lc_reset,
  output logic [MF_W-1:0]  mult_factor,
  output logic             mul_invalid
);
  clk_mode_e        mode_e;
  logic [MUL_W-1:0] mul_q;
  logic [DIV_W-1:0] div_q;
  logic             clkout_off_q;
  logic             lc_en_q;
  logic [MUL_W-1:0] mul_nx;
  logic             lc_en_nx;
  logic             lc_rst_nx;
  logic             off_nx;
  logic             apply_ok;

  assign mode_e   = clk_mode_e'(mode);
  assign apply_ok = lock_ok || (mode_e == MODE_EXT);

  sc_ctrl_regs #(
    .MUL_W(MUL_W), .DIV_W(DIV_W), .RST_MUL(RST_MUL), .RST_DIV(RST_DIV)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pll_lock(pll_lock), .stop_pll_off(stop_pll_off), .mode_e(mode_e),
    .mul_q(mul_q), .div_q(div_q), .clkout_off_q(clkout_off_q),
    .lc_en_q(lc_en_q), .mul_nx(mul_nx), .lc_en_nx(lc_en_nx),
    .lc_rst_nx(lc_rst_nx), .off_nx(off_nx),
    .lock_ok(lock_ok), .relock_req(relock_req)
  );

  sc_post_div #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_div (
    .clk(clk), .rst(rst), .div_req(div_q), .apply_ok(apply_ok),
    .off_nx(off_nx), .sys_clk(sys_clk), .clkout(clkout),
    .div_active(div_active)
  );

  sc_status #(.MUL_W(MUL_W)) u_stat (
    .clk(clk), .rst(rst), .mul_nx(mul_nx), .lc_en_nx(lc_en_nx),
    .lc_rst_nx(lc_rst_nx), .lc_flag(lc_flag), .ref_slow(ref_slow),
    .mode_e(mode_e), .lc_reset(lc_reset), .mult_factor(mult_factor),
    .mul_invalid(mul_invalid)
  );
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
  parameter int MUL_W = 3,
  parameter int DIV_W = 3,
  parameter int WR_W  = 9,
  parameter int MF_W  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [WR_W-1:0]  wr_data,
  input logic [1:0]       mode,
  input logic             stop_pll_off,
  input logic             sys_clk,
  input logic             clkout,
  input logic [DIV_W-1:0] div_active,
  input logic             lock_ok,
  input logic             relock_req,
  input logic             lc_reset,
  input logic [MF_W-1:0]  mult_factor,
  input logic [MUL_W-1:0] mul_q,
  input logic             clkout_off_q,
  input logic             lc_en_q
);
  assert_div_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    (div_active != $past(div_active)) |-> ($past(sys_clk) && !sys_clk));

  assert_relock_on_mul_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_data[MUL_W-1:0] != mul_q) && (mode != 2'd1) && (mode != 2'd2))
      |=> (relock_req && !lock_ok));

  assert_one_to_one_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1) |=> (mult_factor == MF_W'(1)));

  assert_lc_gate_R6: assert property (@(posedge clk) disable iff (rst)
    !lc_en_q |-> !lc_reset);

  assert_clkout_low_R7: assert property (@(posedge clk) disable iff (rst)
    clkout_off_q |-> !clkout);

  assert_stop_relock_R8: assert property (@(posedge clk) disable iff (rst)
    stop_pll_off |=> (relock_req && !lock_ok));

  assert_hold_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
    (!lock_ok && (mode != 2'd2)) |=> $stable(div_active));
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(
  .MUL_W(MUL_W), .DIV_W(DIV_W), .WR_W(WR_W), .MF_W(MF_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
  .stop_pll_off(stop_pll_off), .sys_clk(sys_clk), .clkout(clkout),
  .div_active(div_active), .lock_ok(lock_ok), .relock_req(relock_req),
  .lc_reset(lc_reset), .mult_factor(mult_factor), .mul_q(mul_q),
  .clkout_off_q(clkout_off_q), .lc_en_q(lc_en_q)
);

// File: tb/sysclk_ctrl_tb.sv
`timescale 1ns/1ps
module sysclk_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic       pll_lock = 1'b1;
  logic       stop_pll_off = 1'b0;
  logic       lc_flag = 1'b0;
  logic       ref_slow = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       sys_clk, clkout, lock_ok, relock_req, lc_reset, mul_invalid;
  logic [2:0] div_active;
  logic [4:0] mult_factor;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [2:0] cur_m = 3'd1;
  logic [2:0] cur_r = 3'd0;
  logic       cur_lce = 1'b0, cur_lcr = 1'b0, cur_off = 1'b0;

  always #5 clk = !clk;

  sysclk_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pll_lock(pll_lock), .stop_pll_off(stop_pll_off), .lc_flag(lc_flag),
    .ref_slow(ref_slow), .mode(mode), .sys_clk(sys_clk), .clkout(clkout),
    .div_active(div_active), .lock_ok(lock_ok), .relock_req(relock_req),
    .lc_reset(lc_reset), .mult_factor(mult_factor), .mul_invalid(mul_invalid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  // R3 monitor: divide code may change only on a sampled 1->0 of sys_clk
  logic       prev_sys = 1'b0;
  logic [2:0] prev_div = 3'd0;
  always @(negedge clk) begin
    if (!rst && div_active != prev_div)
      chk(prev_sys && !sys_clk, "R3 divide change off falling edge", int'(sys_clk), 0);
    prev_sys = sys_clk;
    prev_div = div_active;
  end

  task automatic write_word();
    wr_data = {cur_off, cur_lcr, cur_lce, cur_r, cur_m};
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic relock();
    pll_lock = 1'b0;
    @(negedge clk);
    pll_lock = 1'b1;
    @(negedge clk);
    chk(lock_ok == 1'b1, "R4 lock returns after pll_lock low", int'(lock_ok), 1);
  endtask

  task automatic wait_div(input logic [2:0] r);
    for (int i = 0; i < 600 && div_active != r; i++) @(negedge clk);
  endtask

  task automatic measure(input logic [2:0] r);
    int hi, lo, lim;
    lim = 0;
    while (!(prev_sys == 1'b0 && sys_clk == 1'b1) && lim < 600) begin
      @(negedge clk);
      lim++;
    end
    hi = 1;
    @(negedge clk);
    while (sys_clk && hi < 600) begin hi++; @(negedge clk); end
    lo = 1;
    @(negedge clk);
    while (!sys_clk && lo < 600) begin lo++; @(negedge clk); end
    chk(hi == (1 << r), "R2 high phase length", hi, 1 << r);
    chk(lo == (1 << r), "R2 low phase length", lo, 1 << r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sys_clk == 1'b0 && clkout == 1'b0, "R2 sys_clk low in reset", int'(sys_clk), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(mult_factor == 5'd6, "R1 reset multiplier", int'(mult_factor), 6);
    chk(div_active == 3'd0, "R2 reset divide code", int'(div_active), 0);
    chk(relock_req == 1'b0 && lc_reset == 1'b0, "R4 no request after reset", int'(relock_req), 0);
    chk(lock_ok == 1'b1, "R4 lock follows pll_lock", int'(lock_ok), 1);

    // R4: same M write has no effect
    write_word();
    chk(relock_req == 1'b0 && lock_ok == 1'b1, "R4 same-M write", int'(relock_req), 0);

    // R1/R4 multiply sweep in normal mode
    for (int m = 0; m < 8; m++) begin
      if (m == 1) continue;
      cur_m = 3'(m);
      write_word();
      chk(mult_factor == 5'(2 * (m + 2)), "R1 multiplier", int'(mult_factor), 2 * (m + 2));
      chk(relock_req == 1'b1, "R4 relock request", int'(relock_req), 1);
      chk(lock_ok == 1'b0, "R4 lock dropped", int'(lock_ok), 0);
      @(negedge clk);
      chk(relock_req == 1'b0, "R4 relock single pulse", int'(relock_req), 0);
      chk(lock_ok == 1'b0, "R4 lock held low until pll_lock low", int'(lock_ok), 0);
      relock();
    end
    cur_m = 3'd1;
    write_word();
    relock();

    // R2/R3 divide sweep
    for (int r = 0; r < 8; r++) begin
      cur_r = 3'(r);
      write_word();
      chk(relock_req == 1'b0 && lock_ok == 1'b1, "R3 divide write keeps lock", int'(lock_ok), 1);
      wait_div(3'(r));
      chk(div_active == 3'(r), "R2 divide applied", int'(div_active), r);
      measure(3'(r));
    end
    cur_r = 3'd1;
    write_word();
    wait_div(3'd1);

    // R7 clock output gating
    cur_off = 1'b1;
    write_word();
    for (int i = 0; i < 16; i++) begin
      chk(clkout == 1'b0, "R7 clkout held low", int'(clkout), 0);
      @(negedge clk);
    end
    cur_off = 1'b0;
    write_word();
    for (int i = 0; i < 16; i++) begin
      chk(clkout == sys_clk, "R7 clkout follows sys_clk", int'(clkout), int'(sys_clk));
      @(negedge clk);
    end

    // R9 divide write held while unlocked
    pll_lock = 1'b0;
    repeat (2) @(negedge clk);
    cur_r = 3'd3;
    write_word();
    repeat (40) @(negedge clk);
    chk(div_active == 3'd1, "R9 divide held while unlocked", int'(div_active), 1);
    pll_lock = 1'b1;
    wait_div(3'd3);
    chk(div_active == 3'd3, "R9 divide applied after lock", int'(div_active), 3);
    measure(3'd3);
    cur_r = 3'd0;
    write_word();
    wait_div(3'd0);

    // R6 loss-of-clock reset gating
    lc_flag = 1'b1;
    for (int e = 0; e < 4; e++) begin
      cur_lce = e[0];
      cur_lcr = e[1];
      write_word();
      chk(lc_reset == (e == 3), "R6 loss-of-clock reset", int'(lc_reset), int'(e == 3));
    end
    mode = 2'd2;
    @(negedge clk);
    @(negedge clk);
    chk(lc_reset == 1'b0, "R6 external mode blocks reset", int'(lc_reset), 0);
    mode = 2'd0;
    lc_flag = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(lc_reset == 1'b0, "R6 no flag no reset", int'(lc_reset), 0);

    // R8 stop-mode PLL off, with loss-of-clock enable on and off
    for (int k = 0; k < 2; k++) begin
      cur_lce = k[0];
      cur_lcr = 1'b0;
      write_word();
      stop_pll_off = 1'b1;
      @(negedge clk);
      stop_pll_off = 1'b0;
      chk(relock_req == 1'b1 && lock_ok == 1'b0, "R8 stop drops lock", int'(lock_ok), 0);
      relock();
    end

    // R5 one-to-one and external modes
    for (int md = 1; md < 3; md++) begin
      mode = 2'(md);
      @(negedge clk);
      cur_m = 3'd5;
      write_word();
      chk(mult_factor == 5'd1, "R5 multiplier is one", int'(mult_factor), 1);
      chk(relock_req == 1'b0 && lock_ok == 1'b1, "R5 M write no relock", int'(relock_req), 0);
      cur_m = 3'd1;
      write_word();
    end
    mode = 2'd0;
    @(negedge clk);

    // R10 invalid multiplier flag
    cur_m = 3'd0;
    ref_slow = 1'b1;
    write_word();
    chk(mul_invalid == 1'b1, "R10 M=0 with slow reference", int'(mul_invalid), 1);
    relock();
    ref_slow = 1'b0;
    @(negedge clk);
    chk(mul_invalid == 1'b0, "R10 fast reference", int'(mul_invalid), 0);
    ref_slow = 1'b1;
    mode = 2'd1;
    @(negedge clk);
    chk(mul_invalid == 1'b0, "R10 ignored in one-to-one", int'(mul_invalid), 0);
    mode = 2'd0;
    cur_m = 3'd2;
    write_word();
    chk(mul_invalid == 1'b0, "R10 nonzero M", int'(mul_invalid), 0);
    relock();

    finish_run();
  end
endmodule